// File: doc/BRIEF.md
# Bidirectional Mailbox Register Pair

This block carries single words of mail between two ports, A and B, that run on unrelated clocks. It is a side channel next to a data queue. There is one mail register for each direction. A port writes a word into the register bound for the other side, and that side's active-low full flag drops. When the receiving port reads the word, the flag returns high. The stored word does not change when it is read. It changes only when the sending port writes again.

Each port has a chip select, a write/read select (1 = write, 0 = read), an enable and a mailbox select. A mailbox access takes place on the rising edge of that port's clock when chip select, enable and mailbox select are all high. The write/read select then chooses the direction.

The static bus-size input limits which lanes carry mail on both ports. Mail is never reordered or width-converted. Each direction crosses the clock boundary with a toggle request and acknowledge pair through two-stage synchronizers. The sending side holds a stable launch register, and the receiving side captures that register into its own copy.

The sending side runs a finite state machine with three states. TX_IDLE has nothing in flight. TX_WAIT has one word launched and is waiting for its acknowledge. TX_WAIT_MORE has one word launched and a newer word parked.

Its transitions are:
- launch (TX_IDLE to TX_WAIT).
- park (TX_WAIT to TX_WAIT_MORE).
- retire (TX_WAIT to TX_IDLE).
- relaunch (TX_WAIT_MORE to TX_WAIT, or TX_WAIT to TX_WAIT when a write meets the acknowledge).

The receiving side runs a finite state machine with two states, RX_EMPTY and RX_FULL. Its transitions are:
- arrive (to RX_FULL).
- drain (RX_FULL to RX_EMPTY on a read).

Top module: `mbx_pair`

## Requirements
- R1: An access with chip select, enable or mailbox select low is ignored: the far flag stays as it was and the stored mail word is unchanged.
- R2: A mailbox write on port A (cs=1, wr=1, en=1, mbx=1) drives `b_mail_full_n` low within a bounded number of B clocks. A later B read then returns that word.
- R3: A mailbox read on port B (cs=1, wr=0, en=1, mbx=1) places the stored word on `b_dout` one B clock later and sets `b_mail_full_n` high, unless a new word arrives in that same cycle.
- R4: Mail written on port B is delivered to port A in the same way: `a_mail_full_n` goes low, and an A read returns the word and sets the flag high.
- R5: A read does not alter the stored word, so repeated reads return the same value. `a_dout` and `b_dout` change only on a mailbox read of their own port.
- R6: A write to a mailbox whose flag is already low replaces the word, and the flag stays low until a read.
- R7: `bus_mode` selects the mail lanes on both ports: 2'b00 or 2'b11 gives lanes 0..35, 2'b01 gives lanes 0..17, 2'b10 gives lanes 0..8. Input lanes outside that range are ignored, and output lanes outside it are driven 0.
- R8: Reset (rst_n low) sets both flags high and clears both mail words to 0.
- R9: A read of an empty mailbox leaves its flag high and returns the word held from before.
- R10: Back-to-back writes issued faster than the handshake completes deliver the last written word, with the flag low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| bus_mode | input | 2 | Static lane-width select (R7 encoding) |
| a_cs | input | 1 | Port A chip select |
| a_wr | input | 1 | Port A direction, 1 = write, 0 = read |
| a_en | input | 1 | Port A enable |
| a_mbx | input | 1 | Port A mailbox select |
| a_din | input | 36 | Port A write data |
| a_dout | output | 36 | Port A mail read data |
| a_mail_full_n | output | 1 | Low while mail from B waits for A |
| b_cs | input | 1 | Port B chip select |
| b_wr | input | 1 | Port B direction, 1 = write, 0 = read |
| b_en | input | 1 | Port B enable |
| b_mbx | input | 1 | Port B mailbox select |
| b_din | input | 36 | Port B write data |
| b_dout | output | 36 | Port B mail read data |
| b_mail_full_n | output | 1 | Low while mail from A waits for B |

## Verification
The hardest state to reach is TX_WAIT_MORE. It needs a second write to land while the first word's request and acknowledge are still crossing the two synchronizer chains, and single spaced writes never get there. The bench holds the write qualifiers high for several consecutive clocks on the faster port. It does this in directed form and again inside the randomized sequence, so that parking and relaunch both occur. It then checks that only the last word is delivered.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    parameter int unsigned MBX_DW = 36;

    typedef enum logic [1:0] {
        BUS_LONG   = 2'b00,
        BUS_WORD   = 2'b01,
        BUS_BYTE   = 2'b10,
        BUS_LONG_R = 2'b11
    } bus_mode_e;

    typedef enum logic [1:0] {
        TX_IDLE      = 2'b00,
        TX_WAIT      = 2'b01,
        TX_WAIT_MORE = 2'b10
    } tx_state_e;

    typedef enum logic {
        RX_EMPTY = 1'b0,
        RX_FULL  = 1'b1
    } rx_state_e;

endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d};
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/mbx_lane_mask.sv
module mbx_lane_mask
    import mbx_pkg::*;
#(
    parameter int unsigned DW = MBX_DW
) (
    input  logic [1:0]    mode,
    output logic [DW-1:0] mask
);
    localparam int unsigned LW        = $clog2(DW + 1);
    localparam int unsigned LANES_HALF = DW / 2;
    localparam int unsigned LANES_QTR  = DW / 4;

    logic [LW-1:0] limit;

    always_comb begin
        unique case (bus_mode_e'(mode))
            BUS_WORD: limit = LW'(LANES_HALF);
            BUS_BYTE: limit = LW'(LANES_QTR);
            default:  limit = LW'(DW);
        endcase
    end

    for (genvar i = 0; i < DW; i++) begin : g_lane
        assign mask[i] = (LW'(i) < limit);
    end
endmodule

// File: rtl/mbx_tx_side.sv
module mbx_tx_side
    import mbx_pkg::*;
#(
    parameter int unsigned DW      = MBX_DW,
    parameter int unsigned SYNC_ST = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_go,
    input  logic [DW-1:0] wr_data,
    input  logic [DW-1:0] lane_mask,
    input  logic          ack_in,
    output logic          req_out,
    output logic [DW-1:0] launch_data
);
    tx_state_e     state_q, state_d;
    logic          ack_s;
    logic          ack_done;
    logic          launch_now;
    logic          launch_from_pend;
    logic          park;
    logic          req_q;
    logic [DW-1:0] launch_q;
    logic [DW-1:0] pend_q;
    logic [DW-1:0] wr_masked;

    mbx_sync #(.STAGES(SYNC_ST)) u_ack_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ack_in),
        .q     (ack_s)
    );

    assign ack_done  = (ack_s == req_q);
    assign wr_masked = wr_data & lane_mask;

    // next-state and transition decode
    always_comb begin
        state_d          = state_q;
        launch_now       = 1'b0;
        launch_from_pend = 1'b0;
        park             = 1'b0;
        unique case (state_q)
            TX_IDLE: begin
                if (wr_go) begin
                    launch_now = 1'b1;           // launch
                    state_d    = TX_WAIT;
                end
            end
            TX_WAIT: begin
                if (ack_done) begin
                    if (wr_go) begin
                        launch_now = 1'b1;       // relaunch
                    end else begin
                        state_d = TX_IDLE;       // retire
                    end
                end else if (wr_go) begin
                    park    = 1'b1;              // park
                    state_d = TX_WAIT_MORE;
                end
            end
            TX_WAIT_MORE: begin
                if (ack_done) begin
                    launch_now       = 1'b1;     // relaunch
                    launch_from_pend = !wr_go;
                    state_d          = TX_WAIT;
                end else if (wr_go) begin
                    park = 1'b1;
                end
            end
            default: state_d = TX_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q    <= 1'b0;
            launch_q <= '0;
            pend_q   <= '0;
        end else begin
            if (launch_now) begin
                req_q    <= ~req_q;
                launch_q <= launch_from_pend ? pend_q : wr_masked;
            end
            if (park) begin
                pend_q <= wr_masked;
            end
        end
    end

    assign req_out     = req_q;
    assign launch_data = launch_q;
endmodule

// File: rtl/mbx_rx_side.sv
module mbx_rx_side
    import mbx_pkg::*;
#(
    parameter int unsigned DW      = MBX_DW,
    parameter int unsigned SYNC_ST = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_in,
    input  logic [DW-1:0] launch_in,
    input  logic          rd_go,
    input  logic [DW-1:0] lane_mask,
    output logic          ack_out,
    output logic [DW-1:0] dout,
    output logic          full_n,
    output logic          arrive
);
    rx_state_e     state_q, state_d;
    logic          req_s;
    logic          req_seen_q;
    logic [DW-1:0] hold_q;
    logic [DW-1:0] dout_q;

    mbx_sync #(.STAGES(SYNC_ST)) u_req_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (req_in),
        .q     (req_s)
    );

    assign arrive = req_s ^ req_seen_q;

    // next-state: arrival has priority over a read in the same cycle
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_EMPTY: if (arrive) state_d = RX_FULL;          // arrive
            RX_FULL: begin
                if (arrive)     state_d = RX_FULL;            // arrive (overwrite)
                else if (rd_go) state_d = RX_EMPTY;           // drain
            end
            default: state_d = RX_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_seen_q <= 1'b0;
            hold_q     <= '0;
            dout_q     <= '0;
        end else begin
            req_seen_q <= req_s;
            if (arrive) begin
                hold_q <= launch_in;
            end
            if (rd_go) begin
                dout_q <= hold_q & lane_mask;
            end
        end
    end

    assign ack_out = req_seen_q;
    assign dout    = dout_q;
    assign full_n  = (state_q != RX_FULL);
endmodule

// File: rtl/mbx_pair.sv
module mbx_pair
    import mbx_pkg::*;
#(
    parameter int unsigned DW      = MBX_DW,
    parameter int unsigned SYNC_ST = 2
) (
    input  logic          clk_a,
    input  logic          clk_b,
    input  logic          rst_n,
    input  logic [1:0]    bus_mode,
    input  logic          a_cs,
    input  logic          a_wr,
    input  logic          a_en,
    input  logic          a_mbx,
    input  logic [DW-1:0] a_din,
    output logic [DW-1:0] a_dout,
    output logic          a_mail_full_n,
    input  logic          b_cs,
    input  logic          b_wr,
    input  logic          b_en,
    input  logic          b_mbx,
    input  logic [DW-1:0] b_din,
    output logic [DW-1:0] b_dout,
    output logic          b_mail_full_n
);
    localparam int unsigned NPORT = 2;   // index 0 = port A, 1 = port B

    logic [NPORT-1:0] port_clk;
    logic [NPORT-1:0] port_sel;
    logic [NPORT-1:0] port_dir;
    logic [NPORT-1:0] port_wr_go;
    logic [NPORT-1:0] port_rd_go;
    logic [NPORT-1:0] port_full_n;
    logic [DW-1:0]    port_din  [NPORT];
    logic [DW-1:0]    port_dout [NPORT];

    // channel ch goes from port ch to port (1-ch)
    logic [NPORT-1:0] ch_req;
    logic [NPORT-1:0] ch_ack;
    logic [DW-1:0]    ch_launch [NPORT];
    logic [NPORT-1:0] arrive;    // indexed by channel: 0 = A->B, 1 = B->A

    logic [DW-1:0]    lane_mask;

    assign port_clk    = {clk_b, clk_a};
    assign port_sel    = {b_cs & b_en & b_mbx, a_cs & a_en & a_mbx};
    assign port_dir    = {b_wr, a_wr};
    assign port_din[0] = a_din;
    assign port_din[1] = b_din;

    mbx_lane_mask #(.DW(DW)) u_lane_mask (
        .mode (bus_mode),
        .mask (lane_mask)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        assign port_wr_go[p] = port_sel[p] &  port_dir[p];
        assign port_rd_go[p] = port_sel[p] & ~port_dir[p];
    end

    for (genvar ch = 0; ch < NPORT; ch++) begin : g_chan
        localparam int unsigned RXP = NPORT - 1 - ch;

        mbx_tx_side #(.DW(DW), .SYNC_ST(SYNC_ST)) u_tx (
            .clk         (port_clk[ch]),
            .rst_n       (rst_n),
            .wr_go       (port_wr_go[ch]),
            .wr_data     (port_din[ch]),
            .lane_mask   (lane_mask),
            .ack_in      (ch_ack[ch]),
            .req_out     (ch_req[ch]),
            .launch_data (ch_launch[ch])
        );

        mbx_rx_side #(.DW(DW), .SYNC_ST(SYNC_ST)) u_rx (
            .clk       (port_clk[RXP]),
            .rst_n     (rst_n),
            .req_in    (ch_req[ch]),
            .launch_in (ch_launch[ch]),
            .rd_go     (port_rd_go[RXP]),
            .lane_mask (lane_mask),
            .ack_out   (ch_ack[ch]),
            .dout      (port_dout[RXP]),
            .full_n    (port_full_n[RXP]),
            .arrive    (arrive[ch])
        );
    end

    assign a_dout        = port_dout[0];
    assign b_dout        = port_dout[1];
    assign a_mail_full_n = port_full_n[0];
    assign b_mail_full_n = port_full_n[1];
endmodule

// File: rtl/mbx_pair_chk.sv
module mbx_pair_chk #(
    parameter int unsigned DW = 36
) (
    input logic          clk_a,
    input logic          clk_b,
    input logic          rst_n,
    input logic [1:0]    bus_mode,
    input logic          a_cs,
    input logic          a_wr,
    input logic          a_en,
    input logic          a_mbx,
    input logic [DW-1:0] a_dout,
    input logic          a_mail_full_n,
    input logic          b_cs,
    input logic          b_wr,
    input logic          b_en,
    input logic          b_mbx,
    input logic [DW-1:0] b_dout,
    input logic          b_mail_full_n,
    input logic [1:0]    arrive
);
    logic a_rd, b_rd;
    assign a_rd = a_cs && !a_wr && a_en && a_mbx;
    assign b_rd = b_cs && !b_wr && b_en && b_mbx;

    // R3 / R4: a read without a simultaneous arrival raises the flag
    assert_b_read_clears_R3: assert property (@(posedge clk_b) disable iff (!rst_n)
        (b_rd && !arrive[0]) |=> b_mail_full_n);
    assert_a_read_clears_R4: assert property (@(posedge clk_a) disable iff (!rst_n)
        (a_rd && !arrive[1]) |=> a_mail_full_n);

    // R1: an empty mailbox stays empty unless a word arrives
    assert_b_empty_holds_R1: assert property (@(posedge clk_b) disable iff (!rst_n)
        (b_mail_full_n && !arrive[0]) |=> b_mail_full_n);
    assert_a_empty_holds_R1: assert property (@(posedge clk_a) disable iff (!rst_n)
        (a_mail_full_n && !arrive[1]) |=> a_mail_full_n);

    // R6: a full mailbox stays full until read
    assert_b_full_holds_R6: assert property (@(posedge clk_b) disable iff (!rst_n)
        (!b_mail_full_n && !b_rd) |=> !b_mail_full_n);
    assert_a_full_holds_R6: assert property (@(posedge clk_a) disable iff (!rst_n)
        (!a_mail_full_n && !a_rd) |=> !a_mail_full_n);

    // R5: read data only moves on a read of its own port
    assert_b_dout_stable_R5: assert property (@(posedge clk_b) disable iff (!rst_n)
        !b_rd |=> $stable(b_dout));
    assert_a_dout_stable_R5: assert property (@(posedge clk_a) disable iff (!rst_n)
        !a_rd |=> $stable(a_dout));

    // R7: lanes outside the selected width read as zero
    assert_b_word_lanes_R7: assert property (@(posedge clk_b) disable iff (!rst_n)
        (bus_mode == 2'b01) |-> (b_dout[DW-1:DW/2] == '0));
    assert_b_byte_lanes_R7: assert property (@(posedge clk_b) disable iff (!rst_n)
        (bus_mode == 2'b10) |-> (b_dout[DW-1:DW/4] == '0));
    assert_a_word_lanes_R7: assert property (@(posedge clk_a) disable iff (!rst_n)
        (bus_mode == 2'b01) |-> (a_dout[DW-1:DW/2] == '0));
    assert_a_byte_lanes_R7: assert property (@(posedge clk_a) disable iff (!rst_n)
        (bus_mode == 2'b10) |-> (a_dout[DW-1:DW/4] == '0));
endmodule

bind mbx_pair mbx_pair_chk #(.DW(DW)) i_mbx_pair_chk (
    .clk_a         (clk_a),
    .clk_b         (clk_b),
    .rst_n         (rst_n),
    .bus_mode      (bus_mode),
    .a_cs          (a_cs),
    .a_wr          (a_wr),
    .a_en          (a_en),
    .a_mbx         (a_mbx),
    .a_dout        (a_dout),
    .a_mail_full_n (a_mail_full_n),
    .b_cs          (b_cs),
    .b_wr          (b_wr),
    .b_en          (b_en),
    .b_mbx         (b_mbx),
    .b_dout        (b_dout),
    .b_mail_full_n (b_mail_full_n),
    .arrive        (arrive)
);

// File: tb/test_mbx_pair.sv
module test_mbx_pair;
    localparam int CLK_A_PERIOD = 10;
    localparam int CLK_B_PERIOD = 14;
    localparam int WD_CYCLES    = 150000;
    localparam int SETTLE       = 16;

    logic        clk_a = 1'b0;
    logic        clk_b = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_mode = 2'b00;
    logic        a_cs = 0, a_wr = 0, a_en = 0, a_mbx = 0;
    logic        b_cs = 0, b_wr = 0, b_en = 0, b_mbx = 0;
    logic [35:0] a_din = '0, b_din = '0;
    logic [35:0] a_dout, b_dout;
    logic        a_mail_full_n, b_mail_full_n;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    // model: ab = word waiting for B, ba = word waiting for A
    logic [35:0] exp_ab, exp_ba;
    bit          exp_b_full, exp_a_full;

    always #(CLK_A_PERIOD/2) clk_a = ~clk_a;
    always #(CLK_B_PERIOD/2) clk_b = ~clk_b;

    mbx_pair i_mbx_pair (
        .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n), .bus_mode(bus_mode),
        .a_cs(a_cs), .a_wr(a_wr), .a_en(a_en), .a_mbx(a_mbx),
        .a_din(a_din), .a_dout(a_dout), .a_mail_full_n(a_mail_full_n),
        .b_cs(b_cs), .b_wr(b_wr), .b_en(b_en), .b_mbx(b_mbx),
        .b_din(b_din), .b_dout(b_dout), .b_mail_full_n(b_mail_full_n)
    );

    function automatic logic [35:0] lane_mask(input logic [1:0] m);
        case (m)
            2'b01:   return 36'h0_0003_FFFF;
            2'b10:   return 36'h0_0000_01FF;
            default: return 36'hF_FFFF_FFFF;
        endcase
    endfunction

    function automatic logic [35:0] rnd36();
        return 36'({$urandom(), $urandom()});
    endfunction

    task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (SETTLE) @(negedge clk_b);
        repeat (SETTLE) @(negedge clk_a);
    endtask

    task automatic op_a(input logic cs, wr, en, mbx, input logic [35:0] d);
        @(negedge clk_a);
        a_cs = cs; a_wr = wr; a_en = en; a_mbx = mbx; a_din = d;
        @(negedge clk_a);
        a_cs = 0; a_wr = 0; a_en = 0; a_mbx = 0;
    endtask

    task automatic op_b(input logic cs, wr, en, mbx, input logic [35:0] d);
        @(negedge clk_b);
        b_cs = cs; b_wr = wr; b_en = en; b_mbx = mbx; b_din = d;
        @(negedge clk_b);
        b_cs = 0; b_wr = 0; b_en = 0; b_mbx = 0;
    endtask

    task automatic do_reset(input logic [1:0] m);
        rst_n = 0;
        bus_mode = m;
        a_cs = 0; a_wr = 0; a_en = 0; a_mbx = 0;
        b_cs = 0; b_wr = 0; b_en = 0; b_mbx = 0;
        repeat (3) @(negedge clk_a);
        repeat (3) @(negedge clk_b);
        rst_n = 1;
        repeat (2) @(negedge clk_a);
        exp_ab = '0; exp_ba = '0; exp_b_full = 0; exp_a_full = 0;
    endtask

    // write from A; kind 0..2 drops cs/en/mbx, otherwise a valid write
    task automatic send_a(input logic [35:0] d, input int kind, input string req);
        op_a(kind != 0, 1'b1, kind != 1, kind != 2, d);
        if (kind > 2) begin exp_ab = d & lane_mask(bus_mode); exp_b_full = 1; end
        settle();
        check(req, {35'd0, b_mail_full_n}, {35'd0, !exp_b_full});
    endtask

    task automatic send_b(input logic [35:0] d, input int kind, input string req);
        op_b(kind != 0, 1'b1, kind != 1, kind != 2, d);
        if (kind > 2) begin exp_ba = d & lane_mask(bus_mode); exp_a_full = 1; end
        settle();
        check(req, {35'd0, a_mail_full_n}, {35'd0, !exp_a_full});
    endtask

    task automatic recv_b(input string req);
        check(req, {35'd0, b_mail_full_n}, {35'd0, !exp_b_full});
        op_b(1, 0, 1, 1, rnd36());
        check(req, b_dout, exp_ab);
        check(req, {35'd0, b_mail_full_n}, 36'd1);
        exp_b_full = 0;
    endtask

    task automatic recv_a(input string req);
        check(req, {35'd0, a_mail_full_n}, {35'd0, !exp_a_full});
        op_a(1, 0, 1, 1, rnd36());
        check(req, a_dout, exp_ba);
        check(req, {35'd0, a_mail_full_n}, 36'd1);
        exp_a_full = 0;
    endtask

    task automatic burst_a(input int n);
        logic [35:0] d;
        @(negedge clk_a);
        a_cs = 1; a_wr = 1; a_en = 1; a_mbx = 1;
        for (int i = 0; i < n; i++) begin
            d = rnd36();
            a_din = d;
            @(negedge clk_a);
        end
        a_cs = 0; a_wr = 0; a_en = 0; a_mbx = 0;
        exp_ab = d & lane_mask(bus_mode); exp_b_full = 1;
        settle();
        check("R10", {35'd0, b_mail_full_n}, 36'd0);
    endtask

    task automatic burst_b(input int n);
        logic [35:0] d;
        @(negedge clk_b);
        b_cs = 1; b_wr = 1; b_en = 1; b_mbx = 1;
        for (int i = 0; i < n; i++) begin
            d = rnd36();
            b_din = d;
            @(negedge clk_b);
        end
        b_cs = 0; b_wr = 0; b_en = 0; b_mbx = 0;
        exp_ba = d & lane_mask(bus_mode); exp_a_full = 1;
        settle();
        check("R10", {35'd0, a_mail_full_n}, 36'd0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk_a);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'h1bad_5eed));

        // R8: reset state
        do_reset(2'b00);
        check("R8", {34'd0, a_mail_full_n, b_mail_full_n}, 36'd3);
        // R9 / R8: read of an empty mailbox returns the cleared word, flag stays high
        recv_b("R9");
        recv_a("R8");

        // R2 / R3 / R5: deliver A->B and read it twice
        send_a(36'hA_5A5A_5A5A, 3, "R2");
        recv_b("R3");
        recv_b("R5");
        // R4: B->A
        send_b(36'h1_2345_6789, 3, "R4");
        recv_a("R4");
        recv_a("R9");

        // R1: each dropped qualifier is ignored; stored word unchanged
        for (int k = 0; k < 3; k++) begin
            send_a(rnd36(), k, "R1");
            recv_b("R1");
            send_b(rnd36(), k, "R1");
            recv_a("R1");
        end

        // R6: overwrite a full mailbox
        send_a(36'h0_0000_0011, 3, "R6");
        send_a(36'h0_0000_0022, 3, "R6");
        recv_b("R6");
        send_b(36'hF_0000_000F, 3, "R6");
        send_b(36'h7_7777_7777, 3, "R6");
        recv_a("R6");

        // R10: bursts faster than the handshake
        burst_a(5);
        recv_b("R10");
        burst_a(2);
        recv_b("R10");
        burst_b(4);
        recv_a("R10");

        // R7: each bus width, directed all-ones then random traffic
        for (int m = 0; m < 4; m++) begin
            do_reset(2'(m));
            check("R8", {34'd0, a_mail_full_n, b_mail_full_n}, 36'd3);
            send_a(36'hF_FFFF_FFFF, 3, "R7");
            recv_b("R7");
            send_b(36'hF_FFFF_FFFF, 3, "R7");
            recv_a("R7");
            for (int it = 0; it < 30; it++) begin
                int op;
                int kind;
                op   = int'($urandom_range(0, 5));
                kind = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 2)) : 3;
                case (op)
                    0: send_a(rnd36(), kind, "R2");
                    1: send_b(rnd36(), kind, "R4");
                    2: recv_b("R3");
                    3: recv_a("R4");
                    4: begin burst_a(int'($urandom_range(2, 6))); recv_b("R10"); end
                    default: begin burst_b(int'($urandom_range(2, 6))); recv_a("R10"); end
                endcase
            end
        end

        finish_run();
    end
endmodule